// File: doc/BRIEF.md
# Interrupt Source Routing Controller

This block takes the flag lines of a set of peripheral interrupt sources and decides, for each source, which of three consumers handles a raised flag: a DMA controller, a descriptor-driven transfer controller (here called the transfer engine), or the CPU interrupt logic. Three configuration bits per source set the route: a DMA-route bit, a transfer-enable bit and a then-interrupt bit. Together they also decide whether the block asks the peripheral to drop its flag. A per-source transfer counter counts completed engine transfers. When it runs out, engine service for that source ends and the CPU is notified.

Engine requests are served one at a time by a small sequencer. Its states are IDLE, OFFER, XFER and WRAP. In IDLE it picks the pending source with the lowest index and goes to OFFER. OFFER holds `dtc_valid_o` with a one-hot grant until `dtc_ready_i` is seen, then moves to XFER. XFER waits for `dtc_done_i` and then moves to WRAP. WRAP lasts one cycle. In that cycle the block applies the flag clear, the counter decrement and the CPU hand-off, and then returns to IDLE. When a source is routed to both the engine and the CPU, its CPU request is held back until WRAP has completed.

A configuration write port loads the three route bits and the counter of one source. Certain sources are marked by a parameter mask as data-register-cleared classes (for example serial or converter sources). For these, the flag clear comes only from the per-source register-access strobe.

Top module: `isr_router`

## Requirements
- R1: With the DMA-route bit at 1, `dma_req_o[i]` follows the flag. `cpu_irq_o[i]` stays 0 and the source is never offered to the engine, whatever the other two bits hold. `flag_clr_o[i]` is 1 while `dma_ack_i[i]` is 1.
- R2: With the DMA-route bit at 0 and the transfer-enable bit at 0, `cpu_irq_o[i]` equals the flag and `flag_clr_o[i]` stays 0. After reset every source is configured this way.
- R3: With the DMA-route bit at 0, the transfer-enable bit at 1 and the then-interrupt bit at 0, a raised flag is offered to the engine. `flag_clr_o[i]` is 1 during the WRAP cycle and no CPU request is made. The source is not offered again until its flag has gone low.
- R4: With the DMA-route bit at 0 and both other bits at 1, the engine serves the source and `flag_clr_o[i]` stays 0. After WRAP, `cpu_irq_o[i]` is 1 until the flag falls.
- R5: For a source with the transfer-enable bit at 1, `cpu_irq_o[i]` stays 0 from the flag rising until the WRAP cycle of its transfer has passed.
- R6: When several sources are pending, the offered grant is the lowest-index pending source.
- R7: In OFFER, `dtc_valid_o` is 1 and `dtc_grant_o` is one-hot and stable until `dtc_ready_i`. After ready, the sequencer waits for `dtc_done_i` before WRAP, and `dtc_valid_o` is 0 outside OFFER.
- R8: Each WRAP decrements the served source's counter. A load value of 0 stands for 2^CNT_W transfers. The transfer that brings the counter to 0 clears the transfer-enable bit and sets `cpu_irq_o[i]`, which stays 1 until a `cpu_ack_i[i]` pulse, even with the flag low. After that, further flags of that source go to the CPU only.
- R9: For a source in SPECIAL_MASK, `flag_clr_o[i]` equals `reg_access_i[i]`. DMA acknowledges and WRAP cycles never clear it.
- R10: A configuration write (`cfg_we_i`, source `cfg_idx_i`) replaces the route bits and the counter and clears any pending exhausted-count CPU request of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_flag_i | input | NUM_SRC | Peripheral flag levels |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source written |
| cfg_dma_sel_i | input | 1 | DMA-route bit |
| cfg_dtc_en_i | input | 1 | Transfer-enable bit |
| cfg_dtc_irq_i | input | 1 | Then-interrupt bit |
| cfg_count_i | input | CNT_W | Transfer count (0 = 2^CNT_W) |
| dma_ack_i | input | NUM_SRC | DMA controller served the source |
| reg_access_i | input | NUM_SRC | Engine touched the data register of a special source |
| dma_req_o | output | NUM_SRC | Requests to the DMA controller |
| flag_clr_o | output | NUM_SRC | Flag clear pulses to peripherals |
| dtc_valid_o | output | 1 | Transfer request valid |
| dtc_grant_o | output | NUM_SRC | One-hot source being offered or served |
| dtc_ready_i | input | 1 | Engine accepts the offer |
| dtc_done_i | input | 1 | Engine finished the transfer |
| cpu_irq_o | output | NUM_SRC | CPU interrupt request levels |
| cpu_ack_i | input | NUM_SRC | CPU acknowledge of an exhausted-count request |

## Verification
The assertions assume that the configuration of a source is not rewritten while that source is being served. They also assume that `dtc_ready_i` is asserted only while an offer is open and that `dtc_done_i` is asserted only in XFER. The stimulus writes configuration only while the sequencer is idle, drives ready and done one cycle each at exactly those points, and keeps flags up through a transfer.

// File: rtl/isr_router_pkg.sv
package isr_router_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_OFFER = 2'd1,
        SEQ_XFER  = 2'd2,
        SEQ_WRAP  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] pick_o
);
    always_comb begin
        pick_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
    end

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> ($onehot(pick_o) && (((pick_o - 1'b1) & req_i) == '0))); // R6
endmodule

// File: rtl/isr_src_slice.sv
module isr_src_slice #(
    parameter int CNT_W   = 8,
    parameter bit SPECIAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_i,
    input  logic             cfg_we_i,
    input  logic             cfg_dma_i,
    input  logic             cfg_dtc_i,
    input  logic             cfg_irq_i,
    input  logic [CNT_W-1:0] cfg_cnt_i,
    input  logic             dma_ack_i,
    input  logic             reg_acc_i,
    input  logic             cpu_ack_i,
    input  logic             finish_i,
    output logic             dtc_pend_o,
    output logic             cpu_irq_o,
    output logic             dma_req_o,
    output logic             flag_clr_o
);
    logic             dma_q;
    logic             dtc_q;
    logic             irq_q;
    logic             served_q;
    logic             exh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_xfer;

    assign last_xfer = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_q    <= 1'b0;
            dtc_q    <= 1'b0;
            irq_q    <= 1'b0;
            served_q <= 1'b0;
            exh_q    <= 1'b0;
            cnt_q    <= '0;
        end else if (cfg_we_i) begin
            dma_q    <= cfg_dma_i;
            dtc_q    <= cfg_dtc_i;
            irq_q    <= cfg_irq_i;
            cnt_q    <= cfg_cnt_i;
            served_q <= 1'b0;
            exh_q    <= 1'b0;
        end else begin
            if (finish_i) begin
                cnt_q    <= cnt_q - 1'b1;
                served_q <= 1'b1;
                if (last_xfer) begin
                    dtc_q <= 1'b0;
                    exh_q <= 1'b1;
                end
            end else if (!flag_i) begin
                served_q <= 1'b0;
            end
            if (cpu_ack_i && !(finish_i && last_xfer)) begin
                exh_q <= 1'b0;
            end
        end
    end

    always_comb begin
        dma_req_o  = flag_i & dma_q;
        dtc_pend_o = flag_i & ~dma_q & dtc_q & ~served_q;
        cpu_irq_o  = ~dma_q & ((flag_i & (~dtc_q | (served_q & irq_q))) | exh_q);
        if (SPECIAL) begin
            flag_clr_o = reg_acc_i;
        end else begin
            flag_clr_o = (dma_q & dma_ack_i) | (finish_i & ~irq_q);
        end
    end

    AST_DMA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_q |-> (!cpu_irq_o && !dtc_pend_o)); // R1
    AST_EXHAUST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_i && last_xfer && !cfg_we_i) |=> (exh_q && !dtc_q)); // R8
    AST_EXH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exh_q && !cpu_ack_i && !cfg_we_i) |=> exh_q); // R8
endmodule

// File: rtl/isr_dtc_seq.sv
module isr_dtc_seq
    import isr_router_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               ready_i,
    input  logic               done_i,
    output logic               valid_o,
    output logic [NUM_SRC-1:0] grant_o,
    output logic               finish_o,
    output logic               busy_o
);
    seq_state_t         state_q;
    seq_state_t         state_d;
    logic [NUM_SRC-1:0] pick;
    logic [NUM_SRC-1:0] grant_q;

    isr_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (pend_i),
        .pick_o (pick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (|pend_i) state_d = SEQ_OFFER;
            SEQ_OFFER: if (ready_i) state_d = SEQ_XFER;
            SEQ_XFER:  if (done_i)  state_d = SEQ_WRAP;
            SEQ_WRAP:  state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && (|pend_i)) begin
                grant_q <= pick;
            end
        end
    end

    always_comb begin
        valid_o  = 1'b0;
        finish_o = 1'b0;
        busy_o   = 1'b1;
        grant_o  = grant_q;
        unique case (state_q)
            SEQ_IDLE: begin
                busy_o  = 1'b0;
                grant_o = '0;
            end
            SEQ_OFFER: valid_o  = 1'b1;
            SEQ_XFER:  valid_o  = 1'b0;
            SEQ_WRAP:  finish_o = 1'b1;
            default:   busy_o   = 1'b0;
        endcase
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $onehot(grant_o)); // R7
    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(grant_o))); // R7
    AST_WAIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_XFER && !done_i) |=> (state_q == SEQ_XFER)); // R7
endmodule

// File: rtl/isr_router.sv
module isr_router #(
    parameter int                   NUM_SRC      = 16,
    parameter int                   CNT_W        = 8,
    parameter logic [NUM_SRC-1:0]   SPECIAL_MASK = '0,
    localparam int                  IDX_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_flag_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic               cfg_dma_sel_i,
    input  logic               cfg_dtc_en_i,
    input  logic               cfg_dtc_irq_i,
    input  logic [CNT_W-1:0]   cfg_count_i,
    input  logic [NUM_SRC-1:0] dma_ack_i,
    input  logic [NUM_SRC-1:0] reg_access_i,
    output logic [NUM_SRC-1:0] dma_req_o,
    output logic [NUM_SRC-1:0] flag_clr_o,
    output logic               dtc_valid_o,
    output logic [NUM_SRC-1:0] dtc_grant_o,
    input  logic               dtc_ready_i,
    input  logic               dtc_done_i,
    output logic [NUM_SRC-1:0] cpu_irq_o,
    input  logic [NUM_SRC-1:0] cpu_ack_i
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic               finish;
    logic               busy;

    isr_dtc_seq #(.NUM_SRC(NUM_SRC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .ready_i  (dtc_ready_i),
        .done_i   (dtc_done_i),
        .valid_o  (dtc_valid_o),
        .grant_o  (grant),
        .finish_o (finish),
        .busy_o   (busy)
    );

    assign dtc_grant_o = grant;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        isr_src_slice #(
            .CNT_W   (CNT_W),
            .SPECIAL (SPECIAL_MASK[g])
        ) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .flag_i     (src_flag_i[g]),
            .cfg_we_i   (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
            .cfg_dma_i  (cfg_dma_sel_i),
            .cfg_dtc_i  (cfg_dtc_en_i),
            .cfg_irq_i  (cfg_dtc_irq_i),
            .cfg_cnt_i  (cfg_count_i),
            .dma_ack_i  (dma_ack_i[g]),
            .reg_acc_i  (reg_access_i[g]),
            .cpu_ack_i  (cpu_ack_i[g]),
            .finish_i   (finish & grant[g]),
            .dtc_pend_o (pend[g]),
            .cpu_irq_o  (cpu_irq_o[g]),
            .dma_req_o  (dma_req_o[g]),
            .flag_clr_o (flag_clr_o[g])
        );
    end

    AST_DTC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((cpu_irq_o & grant) == '0)); // R5
    AST_NO_DMA_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        dtc_valid_o |-> ((dma_req_o & grant) == '0)); // R1
endmodule

// File: tb/test_isr_router.sv
module test_isr_router;
    localparam int N  = 4;
    localparam int CW = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_flag = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_idx = '0;
    logic         cfg_dma = 1'b0, cfg_dtc = 1'b0, cfg_irq = 1'b0;
    logic [CW-1:0] cfg_cnt = '0;
    logic [N-1:0] dma_ack = '0, reg_acc = '0, cpu_ack = '0;
    logic         ready = 1'b0, done = 1'b0;
    logic [N-1:0] dma_req, flag_clr, grant, cpu_irq;
    logic         valid;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    isr_router #(.NUM_SRC(N), .CNT_W(CW), .SPECIAL_MASK(4'b1000)) i_isr_router (
        .clk(clk), .rst_n(rst_n), .src_flag_i(src_flag),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_dma_sel_i(cfg_dma),
        .cfg_dtc_en_i(cfg_dtc), .cfg_dtc_irq_i(cfg_irq), .cfg_count_i(cfg_cnt),
        .dma_ack_i(dma_ack), .reg_access_i(reg_acc), .dma_req_o(dma_req),
        .flag_clr_o(flag_clr), .dtc_valid_o(valid), .dtc_grant_o(grant),
        .dtc_ready_i(ready), .dtc_done_i(done), .cpu_irq_o(cpu_irq),
        .cpu_ack_i(cpu_ack)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic d, input logic t, input logic q, input logic [CW-1:0] c);
        cfg_idx = 2'(idx); cfg_dma = d; cfg_dtc = t; cfg_irq = q; cfg_cnt = c;
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    // waits for an offer of source idx, then runs one transfer; checks the WRAP-cycle clear
    task automatic serve(input int idx, input logic exp_clr);
        for (int w = 0; w < 10 && !valid; w++) tick();
        chk("R7 valid", 32'(valid), 32'd1);
        chk("R6 grant", 32'(grant), 32'(1 << idx));
        chk("R5 cpu before xfer", 32'(cpu_irq[idx]), 32'd0);
        ready = 1'b1; tick(); ready = 1'b0;
        chk("R7 valid low in XFER", 32'(valid), 32'd0);
        tick(); tick();
        chk("R7 waits for done", 32'(flag_clr[idx] | valid), 32'd0);
        done = 1'b1; tick(); done = 1'b0;
        chk("R3 R4 R9 clear in WRAP", 32'(flag_clr[idx]), 32'(exp_clr));
        chk("R5 cpu in WRAP", 32'(cpu_irq[idx]), 32'd0);
        tick();
    endtask

    function automatic logic [N-1:0] lowbit(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(1 << i);
        return '0;
    endfunction

    initial begin
        #1;
        chk("R2 reset cpu", 32'(cpu_irq), 32'd0);
        chk("R7 reset valid", 32'(valid), 32'd0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R2 reset outputs", 32'({dma_req, flag_clr, grant}), 32'd0);
        src_flag[2] = 1'b1; tick(); tick();
        chk("R2 default route cpu", 32'(cpu_irq[2]), 32'd1);
        chk("R2 default no offer", 32'(valid), 32'd0);
        src_flag[2] = 1'b0; tick();

        // sweep of all route-bit combinations on source 0
        for (int m = 0; m < 8; m++) begin
            logic d, t, q;
            d = m[2]; t = m[1]; q = m[0];
            wr(0, d, t, q, 3'd5);
            src_flag[0] = 1'b1; tick();
            chk("R1 dma_req", 32'(dma_req[0]), 32'(d));
            if (d) begin
                tick();
                chk("R1 no cpu", 32'(cpu_irq[0]), 32'd0);
                chk("R1 no offer", 32'(valid), 32'd0);
                chk("R1 no clear idle", 32'(flag_clr[0]), 32'd0);
                dma_ack[0] = 1'b1; #1;
                chk("R1 clear on ack", 32'(flag_clr[0]), 32'd1);
                dma_ack[0] = 1'b0; tick();
            end else if (!t) begin
                tick();
                chk("R2 cpu follows flag", 32'(cpu_irq[0]), 32'd1);
                chk("R2 no offer", 32'(valid), 32'd0);
                chk("R2 no clear", 32'(flag_clr[0]), 32'd0);
            end else begin
                serve(0, !q);
                chk("R3 R4 cpu after xfer", 32'(cpu_irq[0]), 32'(q));
                tick();
                chk("R3 no re-offer", 32'(valid), 32'd0);
            end
            src_flag[0] = 1'b0; tick(); tick();
            chk("R2 R4 cpu drops with flag", 32'(cpu_irq[0]), 32'd0);
        end

        // priority sweep over every pending pattern
        for (int p = 1; p < 16; p++) begin
            logic [N-1:0] rem;
            for (int s = 0; s < N; s++) wr(s, 1'b0, 1'b1, 1'b0, 3'd0);
            rem = N'(p);
            src_flag = rem;
            tick();
            while (rem != '0) begin
                logic [N-1:0] b;
                int bi;
                b = lowbit(rem);
                bi = 0;
                for (int i = 0; i < N; i++) if (b[i]) bi = i;
                serve(bi, bi != 3);
                rem = rem & ~b;
            end
            chk("R6 all served", 32'(valid), 32'd0);
            src_flag = '0; tick(); tick();
        end

        // count exhaustion with then-interrupt set
        wr(1, 1'b0, 1'b1, 1'b1, 3'd2);
        src_flag[1] = 1'b1;
        serve(1, 1'b0);
        chk("R4 cpu after first", 32'(cpu_irq[1]), 32'd1);
        src_flag[1] = 1'b0; tick(); tick();
        chk("R4 cpu clears", 32'(cpu_irq[1]), 32'd0);
        src_flag[1] = 1'b1;
        serve(1, 1'b0);
        src_flag[1] = 1'b0; tick();
        chk("R8 exhausted cpu held", 32'(cpu_irq[1]), 32'd1);
        tick();
        chk("R8 still held", 32'(cpu_irq[1]), 32'd1);
        cpu_ack[1] = 1'b1; tick(); cpu_ack[1] = 1'b0;
        chk("R8 ack clears", 32'(cpu_irq[1]), 32'd0);
        src_flag[1] = 1'b1; tick(); tick();
        chk("R8 no offer after exhaust", 32'(valid), 32'd0);
        chk("R8 cpu only after exhaust", 32'(cpu_irq[1]), 32'd1);
        src_flag[1] = 1'b0; tick();

        // count load 0 = 2^CW transfers, clear mode
        wr(2, 1'b0, 1'b1, 1'b0, 3'd0);
        for (int k = 0; k < 8; k++) begin
            src_flag[2] = 1'b1;
            serve(2, 1'b1);
            chk("R8 exhaust only at last", 32'(cpu_irq[2]), 32'(k == 7));
            src_flag[2] = 1'b0; tick(); tick();
        end
        chk("R8 held with flag low", 32'(cpu_irq[2]), 32'd1);
        wr(2, 1'b0, 1'b0, 1'b0, 3'd1);
        chk("R10 write drops pending", 32'(cpu_irq[2]), 32'd0);

        // special-class source
        wr(3, 1'b1, 1'b0, 1'b0, 3'd1);
        src_flag[3] = 1'b1; tick();
        dma_ack[3] = 1'b1; #1;
        chk("R9 dma ack no clear", 32'(flag_clr[3]), 32'd0);
        dma_ack[3] = 1'b0; reg_acc[3] = 1'b1; #1;
        chk("R9 access clears", 32'(flag_clr[3]), 32'd1);
        reg_acc[3] = 1'b0; src_flag[3] = 1'b0; tick();
        wr(3, 1'b0, 1'b1, 1'b0, 3'd3);
        src_flag[3] = 1'b1;
        serve(3, 1'b0);
        src_flag[3] = 1'b0; tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule